// File: doc/BRIEF.md
# Multi-Cycle Integer Divider with Divide-Error Trap

This unit divides integers for a 16-bit processor datapath. It takes one quotient bit per clock. There are two operand sizes. In byte mode, a 16-bit dividend is divided by an 8-bit divisor. In word mode, a 32-bit dividend, given as a high word and a low word, is divided by a 16-bit divisor. Either size can run unsigned or as two's-complement signed. Quotient and remainder come back in a fixed pair of result registers.

A caller pulses `start` with the operands. Some time later the unit pulses `done` for one cycle. If the quotient does not fit its destination, or the divisor is zero, `div_trap` pulses together with `done`. In that case neither result register is written, so the caller can raise its divide-error exception. No status flags are produced.

Signed division truncates toward zero. The remainder takes the sign of the dividend, and its magnitude is smaller than the divisor's. The signed quotient range includes the most negative value of the destination width.

Top module: `int_divider`

## Requirements
- R1: Byte mode (`wide`=0) divides `dividend_lo` by `divisor[7:0]`. The quotient goes to `result_lo[7:0]` and the remainder to `result_lo[15:8]`. `result_hi`, `dividend_hi` and `divisor[15:8]` play no part: `result_hi` keeps its value.
- R2: Word mode (`wide`=1) divides {`dividend_hi`,`dividend_lo`} by `divisor`. The quotient goes to `result_lo` and the remainder to `result_hi`.
- R3: Unsigned overflow traps. This is the case where the quotient exceeds 255 (byte mode) or 65535 (word mode), which happens exactly when the dividend's upper half is greater than or equal to the divisor. On a trap, `div_trap` rises with `done` and both result registers keep their previous values.
- R4: A zero divisor (only the low 8 bits count in byte mode) traps with `done` one cycle after the edge that samples `start`.
- R5: Signed mode (`signed_op`=1) truncates the quotient toward zero. The remainder takes the sign of the dividend. Operand and result placement are the same as in unsigned mode.
- R6: Signed overflow traps when the quotient lies outside -128..127 (byte mode) or -32768..32767 (word mode). A quotient equal to -128 or -32768 is a valid result.
- R7: Let n be 8 in byte mode and 16 in word mode. Some cases trap early: a zero divisor, or a dividend magnitude at least the divisor magnitude times 2^n. These show `done` in the cycle after the edge that samples `start`. All other cases show `done` after the (n+1)-th following edge. `done` is high for exactly one cycle, and `div_trap` is never high without `done`.
- R8: A `start` pulse while a division is in progress is ignored. The running division completes unchanged.
- R9: After reset, `done`, `div_trap`, `result_lo` and `result_hi` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a division (accepted only when idle) |
| wide | input | 1 | 1 = word mode, 0 = byte mode |
| signed_op | input | 1 | 1 = two's-complement operands |
| dividend_hi | input | 16 | Upper dividend word (word mode only) |
| dividend_lo | input | 16 | Lower dividend word, or the whole byte-mode dividend |
| divisor | input | 16 | Divisor (low byte in byte mode) |
| result_lo | output | 16 | Word quotient, or {remainder, quotient} in byte mode |
| result_hi | output | 16 | Word remainder |
| done | output | 1 | One-cycle completion pulse |
| div_trap | output | 1 | Divide-error trap request, valid with `done` |

## Verification
The bench checks `done`, `div_trap` and both result registers on every cycle. Any bad internal state therefore shows up at the ports in a specific way:
- A miscounted iteration counter moves the `done` pulse off its predicted cycle.
- A wrong restoring step corrupts the quotient or remainder, visible in the `done` cycle.
- A result register written by an ignored `start` or by a trapped division changes before its next legitimate write.
- A faulty sign fix-up or range check shows as a wrong sign, or as a trap that is present or missing, in the completion cycle.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        DIV_IDLE = 2'd0,
        DIV_RUN  = 2'd1,
        DIV_FIX  = 2'd2
    } div_state_e;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
    parameter int W = 16
) (
    input  logic         wide,
    input  logic         sgn,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] mag_hi,
    output logic [W-1:0] mag_lo,
    output logic [W-1:0] dmag,
    output logic         qneg,
    output logic         rneg,
    output logic         pre_trap
);
    localparam int H = W / 2;

    // byte-size operands
    logic         b_dvd_neg;
    logic         b_dvs_neg;
    logic [W-1:0] b_mag;
    logic [H-1:0] b_dvs;
    logic [H-1:0] b_dmag;

    // word-size operands
    logic           w_dvd_neg;
    logic           w_dvs_neg;
    logic [2*W-1:0] w_dvd;
    logic [2*W-1:0] w_mag;
    logic [W-1:0]   w_dmag;

    always_comb begin
        b_dvd_neg = sgn & dvd_lo[W-1];
        b_mag     = b_dvd_neg ? (~dvd_lo + 1'b1) : dvd_lo;
        b_dvs     = dvs[H-1:0];
        b_dvs_neg = sgn & b_dvs[H-1];
        b_dmag    = b_dvs_neg ? (~b_dvs + 1'b1) : b_dvs;

        w_dvd     = {dvd_hi, dvd_lo};
        w_dvd_neg = sgn & dvd_hi[W-1];
        w_mag     = w_dvd_neg ? (~w_dvd + 1'b1) : w_dvd;
        w_dvs_neg = sgn & dvs[W-1];
        w_dmag    = w_dvs_neg ? (~dvs + 1'b1) : dvs;

        if (wide) begin
            mag_hi = w_mag[2*W-1:W];
            mag_lo = w_mag[W-1:0];
            dmag   = w_dmag;
            qneg   = w_dvd_neg ^ w_dvs_neg;
            rneg   = w_dvd_neg;
        end else begin
            // upper half of the 16-bit magnitude is the starting partial
            // remainder; the lower half is left-aligned so the shifter
            // feeds it MSB first
            mag_hi = {{H{1'b0}}, b_mag[W-1:H]};
            mag_lo = {b_mag[H-1:0], {H{1'b0}}};
            dmag   = {{H{1'b0}}, b_dmag};
            qneg   = b_dvd_neg ^ b_dvs_neg;
            rneg   = b_dvd_neg;
        end

        // zero divisor, or a magnitude quotient of 2^n or more
        pre_trap = (dmag == '0) || (mag_hi >= dmag);
    end

endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem_in,
    input  logic         bit_in,
    input  logic [W-1:0] dmag,
    output logic [W-1:0] rem_out,
    output logic         qbit
);
    logic [W+1:0] diff;
    logic [W:0]   shifted;

    always_comb begin
        shifted = {rem_in, bit_in};
        diff    = {1'b0, shifted} - {2'b00, dmag};
        qbit    = ~diff[W+1];
        rem_out = qbit ? diff[W-1:0] : shifted[W-1:0];
    end

endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
    parameter int W = 16
) (
    input  logic         wide,
    input  logic         sgn,
    input  logic         qneg,
    input  logic         rneg,
    input  logic [W-1:0] qmag,
    input  logic [W-1:0] rmag,
    output logic [W-1:0] q_out,
    output logic [W-1:0] r_out,
    output logic         ovf
);
    localparam int H = W / 2;
    localparam logic [W-1:0] LIM_WORD = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] LIM_BYTE = {{H{1'b0}}, 1'b1, {(H-1){1'b0}}};

    logic [W-1:0] lim;

    always_comb begin
        lim   = wide ? LIM_WORD : LIM_BYTE;
        // negative quotients may reach the limit itself, positive ones not
        ovf   = sgn && (qneg ? (qmag > lim) : (qmag >= lim));
        q_out = qneg ? (~qmag + 1'b1) : qmag;
        r_out = rneg ? (~rmag + 1'b1) : rmag;
    end

endmodule

// File: rtl/int_divider.sv
module int_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         wide,
    input  logic         signed_op,
    input  logic [W-1:0] dividend_hi,
    input  logic [W-1:0] dividend_lo,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] result_lo,
    output logic [W-1:0] result_hi,
    output logic         done,
    output logic         div_trap
);
    import div_pkg::*;

    localparam int H  = W / 2;
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        div_state_e   st;
        logic [CW-1:0] cnt;
        logic [W-1:0] rem;
        logic [W-1:0] sh;
        logic [W-1:0] quo;
        logic [W-1:0] dmag;
        logic         wide;
        logic         sgn;
        logic         qneg;
        logic         rneg;
        logic [W-1:0] res_lo;
        logic [W-1:0] res_hi;
        logic         done;
        logic         trap;
    } div_regs_t;

    div_regs_t r_d, r_q;

    logic [W-1:0] p_mag_hi, p_mag_lo, p_dmag;
    logic         p_qneg, p_rneg, p_trap;
    logic [W-1:0] s_rem;
    logic         s_qbit;
    logic [W-1:0] f_q, f_r;
    logic         f_ovf;

    logic busy;
    logic op_wide;

    div_operand_prep #(.W(W)) u_prep (
        .wide     (wide),
        .sgn      (signed_op),
        .dvd_hi   (dividend_hi),
        .dvd_lo   (dividend_lo),
        .dvs      (divisor),
        .mag_hi   (p_mag_hi),
        .mag_lo   (p_mag_lo),
        .dmag     (p_dmag),
        .qneg     (p_qneg),
        .rneg     (p_rneg),
        .pre_trap (p_trap)
    );

    div_step #(.W(W)) u_step (
        .rem_in  (r_q.rem),
        .bit_in  (r_q.sh[W-1]),
        .dmag    (r_q.dmag),
        .rem_out (s_rem),
        .qbit    (s_qbit)
    );

    div_sign_fix #(.W(W)) u_fix (
        .wide  (r_q.wide),
        .sgn   (r_q.sgn),
        .qneg  (r_q.qneg),
        .rneg  (r_q.rneg),
        .qmag  (r_q.quo),
        .rmag  (r_q.rem),
        .q_out (f_q),
        .r_out (f_r),
        .ovf   (f_ovf)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.trap = 1'b0;
        unique case (r_q.st)
            DIV_IDLE: begin
                if (start) begin
                    if (p_trap) begin
                        r_d.done = 1'b1;
                        r_d.trap = 1'b1;
                    end else begin
                        r_d.st   = DIV_RUN;
                        r_d.cnt  = wide ? CW'(W) : CW'(H);
                        r_d.rem  = p_mag_hi;
                        r_d.sh   = p_mag_lo;
                        r_d.quo  = '0;
                        r_d.dmag = p_dmag;
                        r_d.wide = wide;
                        r_d.sgn  = signed_op;
                        r_d.qneg = p_qneg;
                        r_d.rneg = p_rneg;
                    end
                end
            end
            DIV_RUN: begin
                r_d.rem = s_rem;
                r_d.quo = {r_q.quo[W-2:0], s_qbit};
                r_d.sh  = {r_q.sh[W-2:0], 1'b0};
                r_d.cnt = r_q.cnt - 1'b1;
                if (r_q.cnt == CW'(1)) begin
                    r_d.st = DIV_FIX;
                end
            end
            DIV_FIX: begin
                r_d.st   = DIV_IDLE;
                r_d.done = 1'b1;
                if (f_ovf) begin
                    r_d.trap = 1'b1;
                end else if (r_q.wide) begin
                    r_d.res_lo = f_q;
                    r_d.res_hi = f_r;
                end else begin
                    r_d.res_lo = {f_r[H-1:0], f_q[H-1:0]};
                end
            end
            default: r_d.st = DIV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= DIV_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != DIV_IDLE);
    assign op_wide   = r_q.wide;
    assign result_lo = r_q.res_lo;
    assign result_hi = r_q.res_hi;
    assign done      = r_q.done;
    assign div_trap  = r_q.trap;

endmodule

// File: rtl/div_checker.sv
module div_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         wide,
    input logic         signed_op,
    input logic [W-1:0] dividend_hi,
    input logic [W-1:0] dividend_lo,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         op_wide,
    input logic [W-1:0] result_lo,
    input logic [W-1:0] result_hi,
    input logic         done,
    input logic         div_trap
);
    localparam int H = W / 2;

    logic idle_start;
    logic zero_dvs;
    logic uns_big;

    assign idle_start = start && !busy;
    assign zero_dvs   = wide ? (divisor == '0) : (divisor[H-1:0] == '0);
    assign uns_big    = wide ? (dividend_hi >= divisor)
                             : (dividend_lo[W-1:H] >= divisor[H-1:0]);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_trap_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        div_trap |-> done);

    assert_zero_divisor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        idle_start && zero_dvs |=> done && div_trap);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        idle_start && !signed_op && uns_big |=> div_trap);

    assert_trap_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        div_trap |-> (result_lo == $past(result_lo)) && (result_hi == $past(result_hi)));

    assert_byte_hi_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done && !op_wide |-> result_hi == $past(result_hi));

    assert_busy_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

endmodule

bind int_divider div_checker #(.W(W)) u_div_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .wide        (wide),
    .signed_op   (signed_op),
    .dividend_hi (dividend_hi),
    .dividend_lo (dividend_lo),
    .divisor     (divisor),
    .busy        (busy),
    .op_wide     (op_wide),
    .result_lo   (result_lo),
    .result_hi   (result_hi),
    .done        (done),
    .div_trap    (div_trap)
);

// File: tb/int_divider_test.sv
module int_divider_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide = 1'b0;
    logic        signed_op = 1'b0;
    logic [15:0] dividend_hi = '0;
    logic [15:0] dividend_lo = '0;
    logic [15:0] divisor = '0;
    logic [15:0] result_lo;
    logic [15:0] result_hi;
    logic        done;
    logic        div_trap;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // model of the architectural result registers
    logic [15:0] m_lo = '0;
    logic [15:0] m_hi = '0;

    always #5 clk = ~clk;

    int_divider #(.W(16)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .wide        (wide),
        .signed_op   (signed_op),
        .dividend_hi (dividend_hi),
        .dividend_lo (dividend_lo),
        .divisor     (divisor),
        .result_lo   (result_lo),
        .result_hi   (result_hi),
        .done        (done),
        .div_trap    (div_trap)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference: returns trap, completion edge index and results
    task automatic model(input bit w, input bit s, input logic [15:0] dh,
                         input logic [15:0] dl, input logic [15:0] dv,
                         output bit trap, output int lat,
                         output logic [15:0] lo, output logic [15:0] hi);
        longint a, d, q, r, am, dm, qmax, qmin;
        int n;
        n = w ? 16 : 8;
        if (w) begin
            a = s ? longint'($signed({dh, dl})) : longint'({dh, dl});
            d = s ? longint'($signed(dv)) : longint'(dv);
        end else begin
            a = s ? longint'($signed(dl)) : longint'(dl);
            d = s ? longint'($signed(dv[7:0])) : longint'(dv[7:0]);
        end
        lo = m_lo;
        hi = m_hi;
        if (d == 0) begin
            trap = 1; lat = 0;
            return;
        end
        am = (a < 0) ? -a : a;
        dm = (d < 0) ? -d : d;
        q  = a / d;
        r  = a % d;
        if (am >= (dm << n)) begin
            trap = 1; lat = 0;
            return;
        end
        lat = n + 1;
        if (s) begin
            qmax = (longint'(1) << (n - 1)) - 1;
            qmin = -(longint'(1) << (n - 1));
        end else begin
            qmax = (longint'(1) << n) - 1;
            qmin = 0;
        end
        trap = (q > qmax) || (q < qmin);
        if (!trap) begin
            if (w) begin
                lo = q[15:0];
                hi = r[15:0];
            end else begin
                lo = {r[7:0], q[7:0]};
            end
        end
    endtask

    task automatic run_op(input string req, input bit w, input bit s,
                          input logic [15:0] dh, input logic [15:0] dl,
                          input logic [15:0] dv, input bit poke);
        bit   e_trap;
        int   lat;
        logic [15:0] e_lo, e_hi;
        model(w, s, dh, dl, dv, e_trap, lat, e_lo, e_hi);
        @(negedge clk);
        wide = w; signed_op = s;
        dividend_hi = dh; dividend_lo = dl; divisor = dv;
        start = 1'b1;
        @(posedge clk);
        for (int j = 0; j <= lat + 1; j++) begin
            @(negedge clk);
            start = 1'b0;
            if (j == lat) begin
                m_lo = e_lo;
                m_hi = e_hi;
            end
            check(req, "done", {15'd0, done}, {15'd0, (j == lat)});
            check(req, "trap", {15'd0, div_trap}, {15'd0, (j == lat) && e_trap});
            check(req, "result_lo", result_lo, m_lo);
            check(req, "result_hi", result_hi, m_hi);
            if (poke && j == 2 && lat > 4) begin
                // R8: a zero-divisor request while busy must be ignored
                start = 1'b1; wide = ~w; divisor = 16'h0000;
                dividend_lo = 16'hFFFF; dividend_hi = 16'hFFFF;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        check("R9", "done", {15'd0, done}, 16'd0);
        check("R9", "trap", {15'd0, div_trap}, 16'd0);
        check("R9", "result_lo", result_lo, 16'd0);
        check("R9", "result_hi", result_hi, 16'd0);

        // R2 word unsigned
        run_op("R2", 1, 0, 16'h0001, 16'h86A0, 16'd300, 0);
        run_op("R2", 1, 0, 16'hFFFE, 16'hFFFF, 16'hFFFF, 0);
        // R1 byte unsigned, upper inputs carry junk
        run_op("R1", 0, 0, 16'hDEAD, 16'd1000, 16'hAB07, 0);
        run_op("R1", 0, 0, 16'h1234, 16'hFEFF, 16'h00FF, 0);
        // R3 unsigned overflow
        run_op("R3", 0, 0, 16'h0000, 16'h0500, 16'h0005, 0);
        run_op("R3", 1, 0, 16'h0010, 16'h0000, 16'h0010, 0);
        // R4 zero divisor
        run_op("R4", 0, 0, 16'h0000, 16'h0123, 16'hFF00, 0);
        run_op("R4", 1, 1, 16'h0000, 16'h0123, 16'h0000, 0);
        // R5 signed truncation and remainder sign
        run_op("R5", 0, 1, 16'h0000, 16'hFF9C, 16'h0007, 0);
        run_op("R5", 0, 1, 16'h0000, 16'h0064, 16'h00F9, 0);
        run_op("R5", 0, 1, 16'h0000, 16'hFF9C, 16'h00F9, 0);
        run_op("R5", 1, 1, 16'hFFFE, 16'h7960, 16'd300, 0);
        run_op("R5", 1, 1, 16'h0001, 16'h86A0, 16'hFED4, 0);
        // R6 signed range edges
        run_op("R6", 0, 1, 16'h0000, 16'hFC00, 16'h0008, 0);
        run_op("R6", 0, 1, 16'h0000, 16'h0400, 16'h0008, 0);
        run_op("R6", 0, 1, 16'h0000, 16'hFF80, 16'h00FF, 0);
        run_op("R6", 1, 1, 16'hFFFF, 16'h0000, 16'h0002, 0);
        run_op("R6", 1, 1, 16'h0001, 16'h0000, 16'h0002, 0);
        run_op("R6", 1, 1, 16'h8000, 16'h0000, 16'hFFFF, 0);
        // R7 latency, checked on every run above, plus back-to-back
        run_op("R7", 1, 0, 16'h0000, 16'h0007, 16'h0002, 0);
        run_op("R7", 0, 0, 16'h0000, 16'h0007, 16'h0002, 0);
        // R8 start while busy
        run_op("R8", 1, 0, 16'h0002, 16'h0000, 16'h0003, 1);
        run_op("R8", 0, 1, 16'h0000, 16'hF000, 16'h0041, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule